// File: doc/BRIEF.md
# Interrupt Vector Base Relocation Controller

This block decides where the interrupt vector table lives: at word address zero, or at the first word of the boot loader area of program memory. The size of the boot area, and so its start address, comes from a two-bit size code. A small control register with two bits sets the choice: a vector-select bit and a change-enable bit. Software can flip the select bit only through a timed two-step write. It first sets change-enable. It then writes the select bit within the next four cycles.

While that sequence is open, the block raises an interrupt-block output, and the CPU uses it to hold off interrupt entry. This output is separate from the global interrupt enable, which the block never touches. The output stays high until the instruction that follows the select write has completed. Two active-low lock inputs also drive it. Together with a flag that says whether code is running from the boot area, they block interrupts when the vectors sit in the other region and that region is locked.

Top module: `ivt_reloc_ctrl`

## Requirements
- R1: After reset, the select bit and change-enable read 0, `vec_base_o` is 0, and `irq_block_o` is 0 while both lock inputs are 1.
- R2: A write with data bit 0 = 0 while change-enable is 0 has no effect on the register.
- R3: A write with data bit 0 = 1 sets change-enable and leaves the select bit unchanged, whatever data bit 1 holds.
- R4: Once set and with no further write, change-enable reads 1 for exactly 4 cycles after the write cycle, then reads 0.
- R5: A write with data bit 0 = 0 while change-enable is 1 loads data bit 1 into the select bit and clears change-enable in the next cycle.
- R6: `irq_block_o` is 1 in the cycle a change-enable write is presented and in every cycle change-enable reads 1.
- R7: After a select write, `irq_block_o` stays 1 up to and including the first later cycle in which `instr_done_i` is 1. It drops in the cycle after that, unless something else holds it.
- R8: `vec_base_o` is 0 when the select bit is 0. When the select bit is 1 it is 0x7000, 0x7800, 0x7C00 or 0x7E00 for `boot_size_i` = 0, 1, 2 or 3.
- R9: With select = 1, `lock_app_n_i` = 0 and `in_boot_i` = 0, the block output is 1. With select = 0, `lock_boot_n_i` = 0 and `in_boot_i` = 1, it is 1. No other lock combination raises it.
- R10: A change-enable write while change-enable is already 1 restarts the 4-cycle window.
- R11: Read data bit 1 is the select bit and bit 0 is change-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 2 | Write data: bit 1 select, bit 0 change-enable |
| instr_done_i | input | 1 | Instruction completion strobe |
| boot_size_i | input | 2 | Boot area size code |
| lock_app_n_i | input | 1 | Lock for the application area, 0 = programmed |
| lock_boot_n_i | input | 1 | Lock for the boot area, 0 = programmed |
| in_boot_i | input | 1 | Code is executing from the boot area |
| vec_base_o | output | 15 | Vector table base word address |
| irq_block_o | output | 1 | Interrupt entry block |
| reg_rdata_o | output | 2 | Read data: bit 1 select, bit 0 change-enable |

## Verification
The bench targets the edges of the enable window. It writes the select bit on the fourth open cycle, one cycle too late, and in the same write that sets change-enable. A design with an off-by-one counter, or one that lets the combined write through, would move the vector base when it should not. Re-arming in the middle of a window checks that the count restarts rather than expiring early. Completion strobes in the cycle of the select write check that the post-write block does not end one instruction early. The four size codes and every lock/region pairing are swept, so a swapped table entry or an inverted lock polarity shows up as a wrong base address or a missing block.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned CTRL_W  = 2;
  localparam int unsigned SEL_BIT = 1;
  localparam int unsigned CEN_BIT = 0;

  typedef struct packed {
    logic sel;
    logic cen;
  } ivt_ctrl_t;

  function automatic ivt_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] d);
    ivt_ctrl_t c;
    c.sel = d[SEL_BIT];
    c.cen = d[CEN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/ivt_cen_timer.sv
module ivt_cen_timer #(
  parameter int unsigned CEN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic cen_o
);
  localparam int unsigned CNT_W = (CEN_CYC > 1) ? $clog2(CEN_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CEN_CYC - 1);

  logic             cen_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q <= 1'b0;
      cnt_q <= '0;
    end else if (set_i) begin
      cen_q <= 1'b1;
      cnt_q <= CNT_LOAD;
    end else if (clr_i) begin
      cen_q <= 1'b0;
      cnt_q <= '0;
    end else if (cen_q) begin
      if (cnt_q == '0) cen_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cen_o = cen_q;

  // R4
  cen_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_q && cnt_q == '0 && !set_i) |=> !cen_q);
  // R10
  cen_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (cen_q && cnt_q == CNT_LOAD));
endmodule

// File: rtl/ivt_base_sel.sv
module ivt_base_sel #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SIZE_W     = 2,
  parameter int unsigned BOOT_MAX_W = 4096
) (
  input  logic              sel_i,
  input  logic [SIZE_W-1:0] boot_size_i,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned NUM_SIZES = 1 << SIZE_W;

  logic [ADDR_W-1:0] start_tbl [NUM_SIZES];

  // each code step halves the boot area; start = top of memory minus area
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_start
    localparam longint unsigned AREA = longint'(BOOT_MAX_W) >> g;
    assign start_tbl[g] = ADDR_W'((longint'(1) << ADDR_W) - AREA);
  end

  assign base_o = sel_i ? start_tbl[boot_size_i] : '0;

  // R8
  base_zero_chk: assert property (@(base_o) !sel_i |-> base_o == '0);
endmodule

// File: rtl/ivt_irq_gate.sv
module ivt_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cen_set_i,
  input  logic cen_i,
  input  logic sel_wr_i,
  input  logic instr_done_i,
  input  logic sel_i,
  input  logic lock_app_n_i,
  input  logic lock_boot_n_i,
  input  logic in_boot_i,
  output logic block_o
);
  logic hold_q;
  logic lock_blk;

  // block until the instruction after the select write has completed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hold_q <= 1'b0;
    else if (sel_wr_i)              hold_q <= 1'b1;
    else if (hold_q && instr_done_i) hold_q <= 1'b0;
  end

  always_comb begin
    lock_blk = 1'b0;
    if (sel_i  && !lock_app_n_i  && !in_boot_i) lock_blk = 1'b1;
    if (!sel_i && !lock_boot_n_i &&  in_boot_i) lock_blk = 1'b1;
  end

  assign block_o = cen_set_i | cen_i | hold_q | lock_blk;

  // R7
  hold_after_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_wr_i |=> block_o);
  // R6
  cen_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_set_i |-> block_o);
endmodule

// File: rtl/ivt_reloc_ctrl.sv
module ivt_reloc_ctrl #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned SIZE_W     = 2,
  parameter int unsigned BOOT_MAX_W = 4096,
  parameter int unsigned CEN_CYC    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [ivt_pkg::CTRL_W-1:0] reg_wdata_i,
  input  logic                      instr_done_i,
  input  logic [SIZE_W-1:0]         boot_size_i,
  input  logic                      lock_app_n_i,
  input  logic                      lock_boot_n_i,
  input  logic                      in_boot_i,
  output logic [ADDR_W-1:0]         vec_base_o,
  output logic                      irq_block_o,
  output logic [ivt_pkg::CTRL_W-1:0] reg_rdata_o
);
  import ivt_pkg::*;

  ivt_ctrl_t wr;
  logic      sel_q;
  logic      cen;
  logic      cen_set;
  logic      sel_wr;

  assign wr      = unpack_ctrl(reg_wdata_i);
  assign cen_set = reg_we_i &  wr.cen;
  assign sel_wr  = reg_we_i & ~wr.cen & cen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (sel_wr) sel_q <= wr.sel;
  end

  ivt_cen_timer #(.CEN_CYC(CEN_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cen_set),
    .clr_i  (sel_wr),
    .cen_o  (cen)
  );

  ivt_base_sel #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .BOOT_MAX_W (BOOT_MAX_W)
  ) u_base (
    .sel_i       (sel_q),
    .boot_size_i (boot_size_i),
    .base_o      (vec_base_o)
  );

  ivt_irq_gate u_gate (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cen_set_i     (cen_set),
    .cen_i         (cen),
    .sel_wr_i      (sel_wr),
    .instr_done_i  (instr_done_i),
    .sel_i         (sel_q),
    .lock_app_n_i  (lock_app_n_i),
    .lock_boot_n_i (lock_boot_n_i),
    .in_boot_i     (in_boot_i),
    .block_o       (irq_block_o)
  );

  always_comb begin
    reg_rdata_o          = '0;
    reg_rdata_o[SEL_BIT] = sel_q;
    reg_rdata_o[CEN_BIT] = cen;
  end

  // R2
  sel_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen |=> $stable(sel_q));
  // R3
  cen_write_sel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_set |=> $stable(sel_q));
  // R5
  sel_write_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_wdata_i[CEN_BIT] && cen) |=> (!cen && sel_q == $past(reg_wdata_i[SEL_BIT])));
endmodule

// File: tb/sim_ivt_reloc_ctrl.sv
module sim_ivt_reloc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] wd = 2'b00;
  logic       idone = 1'b0;
  logic [1:0] bsz = 2'b00;
  logic       lk_app = 1'b1;
  logic       lk_boot = 1'b1;
  logic       inb = 1'b0;
  logic [14:0] base;
  logic       blk;
  logic [1:0] rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ivt_reloc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wd),
    .instr_done_i(idone), .boot_size_i(bsz), .lock_app_n_i(lk_app),
    .lock_boot_n_i(lk_boot), .in_boot_i(inb), .vec_base_o(base),
    .irq_block_o(blk), .reg_rdata_o(rd)
  );

  // behavioural reference model
  int m_sel = 0, m_cen = 0, m_left = 0, m_hold = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_cen = 0; m_left = 0; m_hold = 0;
    end else begin
      bit sw;
      sw = we && !wd[0] && m_cen != 0;
      if (sw) m_hold = 1;
      else if (m_hold != 0 && idone) m_hold = 0;
      if (we && wd[0]) begin
        m_cen = 1; m_left = 4;
      end else if (sw) begin
        m_sel = wd[1]; m_cen = 0; m_left = 0;
      end else if (m_cen != 0) begin
        m_left = m_left - 1;
        if (m_left == 0) m_cen = 0;
      end
    end
  end

  function automatic int exp_base(int sel, int code);
    return sel != 0 ? 32768 - (4096 >> code) : 0;
  endfunction

  function automatic int exp_blk();
    int b;
    b = ((we && wd[0]) || m_cen != 0 || m_hold != 0) ? 1 : 0;
    if (m_sel != 0 && !lk_app && !inb) b = 1;
    if (m_sel == 0 && !lk_boot && inb) b = 1;
    return b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit cmp_en = 1'b0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R8 base", int'(base), exp_base(m_sel, int'(bsz)));
      chk("R6/R7/R9 block", int'(blk), exp_blk());
      chk("R11 rdata", int'(rd), m_sel * 2 + m_cen);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] d);
    we = 1'b1; wd = d; cyc(); we = 1'b0; wd = 2'b00;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1 rdata", int'(rd), 0);
    chk("R1 base", int'(base), 0);
    chk("R1 block", int'(blk), 0);
    cmp_en = 1'b1;

    // R2 select write with window closed is ignored
    wr(2'b10);
    chk("R2 sel ignored", int'(rd), 0);

    // R3 combined write sets only change-enable; R6 block in write cycle
    we = 1'b1; wd = 2'b11; #1;
    chk("R6 block in write cycle", int'(blk), 1);
    cyc(); we = 1'b0; wd = 2'b00;
    chk("R3 cen only", int'(rd), 1);

    // R4 window lasts exactly 4 cycles (already 1 elapsed above)
    cyc(2);
    chk("R4 cen open cycle 3", int'(rd[0]), 1);
    cyc();
    chk("R4 cen open cycle 4", int'(rd[0]), 1);
    cyc();
    chk("R4 cen closed", int'(rd[0]), 0);
    // late select write ignored
    wr(2'b10);
    chk("R4 late sel ignored", int'(rd[1]), 0);

    // R10 rearm restarts the window
    wr(2'b01); cyc(2); wr(2'b01); cyc(2);
    chk("R10 rearm open", int'(rd[0]), 1);
    // R5 select write on the 4th open cycle
    cyc();
    wr(2'b10);
    chk("R5 sel set", int'(rd), 2);
    // R7 done in the write cycle does not count; block holds
    chk("R7 hold", int'(blk), 1);
    cyc(2);
    chk("R7 hold still", int'(blk), 1);
    idone = 1'b1; cyc(); idone = 1'b0;
    chk("R7 released", int'(blk), 0);

    // R8 size sweep
    for (int c = 0; c < 4; c++) begin
      bsz = 2'(c); #1;
      chk("R8 boot start", int'(base), exp_base(1, c));
    end

    // R9 lock combinations
    lk_app = 1'b0; inb = 1'b0; #1;
    chk("R9 app lock blocks", int'(blk), 1);
    inb = 1'b1; #1;
    chk("R9 app lock in boot free", int'(blk), 0);
    lk_app = 1'b1; lk_boot = 1'b0; #1;
    chk("R9 boot lock with sel=1 free", int'(blk), 0);
    lk_boot = 1'b1; inb = 1'b0;
    cyc();

    // random phase; model compared every clock
    for (int i = 0; i < 4000; i++) begin
      we      = ($urandom % 3) == 0;
      wd      = 2'($urandom);
      idone   = ($urandom % 3) == 0;
      bsz     = 2'($urandom);
      lk_app  = ($urandom % 4) != 0;
      lk_boot = ($urandom % 4) != 0;
      inb     = ($urandom % 2) != 0;
      cyc();
    end
    we = 1'b0; cyc(2);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule